// File: doc/BRIEF.md
# Unaligned Predicated Vector Store Splitter

This block takes one vector store request at a time and turns it into the memory write commands needed to place it. The request carries a byte address, a byte count, a full vector of data bytes and a per-byte predicate. The predicate can be ignored, applied as given, or applied inverted. When the address sits on a vector boundary, the request leaves as a single write. When it does not, the request is cut at the next boundary into a low part and a high part. Each part carries its own address, length, data and byte strobes, with the data shifted so that byte 0 of the command is the first byte of that part.

The request side uses a valid/ready handshake. The memory side presents one write command at a time with valid/ready. Every command also carries two flags that tell the memory whether it belongs to a split access. The controller is a three-state machine with states `ST_IDLE`, `ST_PART_LO` and `ST_PART_HI`:

- `ST_IDLE` goes to `ST_PART_LO` when a request is accepted.
- `ST_PART_LO` goes to `ST_PART_HI` when its command is accepted and the high part is non-empty.
- `ST_PART_LO` goes back to `ST_IDLE` when its command is accepted and the high part is empty.
- `ST_PART_HI` goes back to `ST_IDLE` when its command is accepted.

Top module: `vst_unaligned_store_splitter`

## Requirements
- R1: When the low log2(VBYTES) address bits are zero, exactly one command is issued, at the request address with length req_len. Both flags are 0 on it.
- R2: When the address offset is non-zero, the first command goes to the request address. Its length is the smaller of (VBYTES minus offset) and req_len, so it never crosses a vector boundary.
- R3: The second command of a split goes to the request address plus the first length, with length req_len minus the first length. Its data byte i is request byte (first length + i).
- R4: A split whose second length is zero issues only the first command and then returns to idle.
- R5: With req_pred_en=1 and req_pred_inv=0, the strobe of source byte j equals req_pred[j]. With req_pred_en=0, every byte inside the length is enabled.
- R6: With req_pred_en=1 and req_pred_inv=1, a set req_pred[j] clears the strobe of source byte j, and a clear bit sets it.
- R7: Strobe bits at positions at or above the command length are always 0.
- R8: Both wr_double and wr_unaligned are 1 on every command of a request whose address offset is non-zero.
- R9: The first part is issued before the second. req_ready is 0 from the cycle after acceptance until the last command of the request is accepted.
- R10: While wr_valid=1 and wr_ready=0, the command fields do not change in the next cycle.
- R11: After reset, req_ready=1 and wr_valid=0, including when reset is applied in the middle of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Store request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte address of the store |
| req_len | input | clog2(VBYTES)+1 | Number of bytes to store, 0..VBYTES |
| req_data | input | VBYTES*8 | Data bytes, byte 0 in bits 7:0 |
| req_pred | input | VBYTES | Predicate, bit j governs data byte j |
| req_pred_en | input | 1 | 1 applies the predicate |
| req_pred_inv | input | 1 | 1 inverts the predicate sense |
| wr_valid | output | 1 | Write command valid |
| wr_ready | input | 1 | Memory accepts the command |
| wr_addr | output | ADDR_W | Byte address of this command |
| wr_len | output | clog2(VBYTES)+1 | Byte count of this command |
| wr_data | output | VBYTES*8 | Data shifted so byte 0 is the first byte of the part |
| wr_strb | output | VBYTES | Byte enables aligned with wr_data |
| wr_double | output | 1 | Command belongs to a two-part access |
| wr_unaligned | output | 1 | Command belongs to an access with a non-zero offset |

## Verification
The assertions assume that req_len never exceeds VBYTES. Under that bound, the first part of a split ends exactly on a vector boundary, and the boundary and length properties depend on it. The request fields are only sampled in the accepting cycle, so nothing is assumed about them at other times. wr_ready may do anything. The stimulus uses only lengths from 0 to VBYTES, holds each request for one handshake cycle, and stalls the memory side on purpose in one case so that the hold rule is actually exercised.

// File: rtl/vst_pkg.sv
package vst_pkg;

    // Controller states of the store splitter
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PART_LO = 2'd1,
        ST_PART_HI = 2'd2
    } vst_state_t;

endpackage

// File: rtl/vst_split_calc.sv
// Works out the split point and the predicated byte mask of one request.
module vst_split_calc #(
    parameter int VBYTES = 16,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = $clog2(VBYTES) + 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [VBYTES-1:0] pred_i,
    input  logic              pred_en_i,
    input  logic              pred_inv_i,
    output logic              aligned_o,
    output logic [LEN_W-1:0]  size_lo_o,
    output logic [LEN_W-1:0]  size_hi_o,
    output logic [VBYTES-1:0] mask_o
);
    localparam int OFF_W = $clog2(VBYTES);

    logic [OFF_W-1:0] offset;
    logic [LEN_W-1:0] room;

    always_comb begin
        offset    = addr_i[OFF_W-1:0];
        aligned_o = (offset == '0);
        room      = LEN_W'(VBYTES) - LEN_W'(offset);
        if (aligned_o) begin
            size_lo_o = len_i;
        end else if (len_i < room) begin
            size_lo_o = len_i;
        end else begin
            size_lo_o = room;
        end
        size_hi_o = len_i - size_lo_o;
    end

    // Per-byte enable: all-on, direct or inverted predicate
    for (genvar b = 0; b < VBYTES; b++) begin : g_mask
        assign mask_o[b] = pred_en_i ? (pred_i[b] ^ pred_inv_i) : 1'b1;
    end

endmodule

// File: rtl/vst_part_shift.sv
// Moves the bytes of one part down to position 0 and limits the strobes to its length.
module vst_part_shift #(
    parameter int VBYTES = 16,
    parameter int LEN_W  = $clog2(VBYTES) + 1
) (
    input  logic [VBYTES*8-1:0] data_i,
    input  logic [VBYTES-1:0]   mask_i,
    input  logic [LEN_W-1:0]    shamt_i,
    input  logic [LEN_W-1:0]    count_i,
    output logic [VBYTES*8-1:0] data_o,
    output logic [VBYTES-1:0]   strb_o
);
    for (genvar b = 0; b < VBYTES; b++) begin : g_byte
        always_comb begin
            int src;
            src = b + int'(shamt_i);
            data_o[b*8 +: 8] = 8'h00;
            strb_o[b]        = 1'b0;
            if (src < VBYTES) begin
                data_o[b*8 +: 8] = data_i[src*8 +: 8];
                strb_o[b]        = mask_i[src] && (LEN_W'(b) < count_i);
            end
        end
    end

endmodule

// File: rtl/vst_unaligned_store_splitter.sv
module vst_unaligned_store_splitter
    import vst_pkg::*;
#(
    parameter int VBYTES = 16,
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [$clog2(VBYTES):0]     req_len,
    input  logic [VBYTES*8-1:0]         req_data,
    input  logic [VBYTES-1:0]           req_pred,
    input  logic                        req_pred_en,
    input  logic                        req_pred_inv,
    output logic                        wr_valid,
    input  logic                        wr_ready,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic [$clog2(VBYTES):0]     wr_len,
    output logic [VBYTES*8-1:0]         wr_data,
    output logic [VBYTES-1:0]           wr_strb,
    output logic                        wr_double,
    output logic                        wr_unaligned
);
    localparam int OFF_W  = $clog2(VBYTES);
    localparam int LEN_W  = OFF_W + 1;
    localparam int DATA_W = VBYTES * 8;

    vst_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [VBYTES-1:0] mask_q;
    logic [LEN_W-1:0]  size_lo_q, size_hi_q;
    logic              split_q;

    logic              calc_aligned;
    logic [LEN_W-1:0]  calc_lo, calc_hi;
    logic [VBYTES-1:0] calc_mask;
    logic [LEN_W-1:0]  sh_amt, sh_cnt;
    logic              accept;

    vst_split_calc #(.VBYTES(VBYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) calc_i (
        .addr_i    (req_addr),
        .len_i     (req_len),
        .pred_i    (req_pred),
        .pred_en_i (req_pred_en),
        .pred_inv_i(req_pred_inv),
        .aligned_o (calc_aligned),
        .size_lo_o (calc_lo),
        .size_hi_o (calc_hi),
        .mask_o    (calc_mask)
    );

    vst_part_shift #(.VBYTES(VBYTES), .LEN_W(LEN_W)) shift_i (
        .data_i (data_q),
        .mask_i (mask_q),
        .shamt_i(sh_amt),
        .count_i(sh_cnt),
        .data_o (wr_data),
        .strb_o (wr_strb)
    );

    assign accept = req_valid && req_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_PART_LO;
            ST_PART_LO: if (wr_ready)  state_d = (size_hi_q != '0) ? ST_PART_HI : ST_IDLE;
            ST_PART_HI: if (wr_ready)  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            data_q    <= '0;
            mask_q    <= '0;
            size_lo_q <= '0;
            size_hi_q <= '0;
            split_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q    <= req_addr;
                data_q    <= req_data;
                mask_q    <= calc_mask;
                size_lo_q <= calc_lo;
                size_hi_q <= calc_hi;
                split_q   <= !calc_aligned;
            end
        end
    end

    // Outputs per state
    always_comb begin
        req_ready    = 1'b0;
        wr_valid     = 1'b0;
        wr_addr      = addr_q;
        wr_len       = '0;
        wr_double    = 1'b0;
        wr_unaligned = 1'b0;
        sh_amt       = '0;
        sh_cnt       = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_PART_LO: begin
                wr_valid     = 1'b1;
                wr_len       = size_lo_q;
                sh_cnt       = size_lo_q;
                wr_double    = split_q;
                wr_unaligned = split_q;
            end
            ST_PART_HI: begin
                wr_valid     = 1'b1;
                wr_addr      = addr_q + ADDR_W'(size_lo_q);
                wr_len       = size_hi_q;
                sh_amt       = size_lo_q;
                sh_cnt       = size_hi_q;
                wr_double    = split_q;
                wr_unaligned = split_q;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    // ---------------- assertions ----------------
    logic [VBYTES-1:0] beyond_len;
    always_comb begin
        for (int b = 0; b < VBYTES; b++) begin
            beyond_len[b] = (LEN_W'(b) >= wr_len);
        end
    end

    // Input bound the split arithmetic relies on
    assert_req_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len <= LEN_W'(VBYTES)));

    // A command without the split flag starts on a boundary
    assert_aligned_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_unaligned) |-> (wr_addr[OFF_W-1:0] == '0));

    // Split commands never run past a vector boundary
    assert_no_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_double) |->
            ((LEN_W'(wr_addr[OFF_W-1:0]) + wr_len) <= LEN_W'(VBYTES)));

    // The high part starts on a boundary and is never empty
    assert_hi_part_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PART_HI) |-> ((wr_addr[OFF_W-1:0] == '0) && (wr_len != '0)));

    // An empty high part yields no command
    assert_no_empty_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PART_LO && wr_ready && size_hi_q == '0) |=> !wr_valid);

    // No strobe outside the command length
    assert_strb_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_strb & beyond_len) == '0));

    // Acceptance leads straight to a command and a busy request side
    assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (wr_valid && !req_ready));

    // Stalled commands hold still
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_addr) && $stable(wr_len) && $stable(wr_strb) && $stable(wr_data)));

endmodule

// File: tb/vst_unaligned_store_splitter_tb_top.sv
module vst_unaligned_store_splitter_tb_top;
    localparam int VB = 16;
    localparam int AW = 32;
    localparam int LW = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [AW-1:0]  req_addr = '0;
    logic [LW-1:0]  req_len = '0;
    logic [VB*8-1:0] req_data = '0;
    logic [VB-1:0]  req_pred = '0;
    logic           req_pred_en = 1'b0;
    logic           req_pred_inv = 1'b0;
    logic           wr_valid;
    logic           wr_ready = 1'b1;
    logic [AW-1:0]  wr_addr;
    logic [LW-1:0]  wr_len;
    logic [VB*8-1:0] wr_data;
    logic [VB-1:0]  wr_strb;
    logic           wr_double;
    logic           wr_unaligned;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    vst_unaligned_store_splitter #(.VBYTES(VB), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_data(req_data), .req_pred(req_pred),
        .req_pred_en(req_pred_en), .req_pred_inv(req_pred_inv),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_len(wr_len), .wr_data(wr_data), .wr_strb(wr_strb),
        .wr_double(wr_double), .wr_unaligned(wr_unaligned)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [4:0]  len;
        logic        pen;
        logic        pinv;
        logic [15:0] pred;
        logic [1:0]  ncmd;
        logic [4:0]  len_lo;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{32'h00001000, 5'd16, 1'b0, 1'b0, 16'h0000, 2'd1, 5'd16},  // R1 R5
        '{32'h00001003, 5'd16, 1'b1, 1'b0, 16'hA5F0, 2'd2, 5'd13},  // R2 R3 R5
        '{32'h0000100F, 5'd16, 1'b1, 1'b1, 16'h00FF, 2'd2, 5'd1},   // R3 R6
        '{32'h00001008, 5'd4,  1'b0, 1'b0, 16'h0000, 2'd1, 5'd4},   // R4
        '{32'h00001008, 5'd8,  1'b1, 1'b0, 16'h00C3, 2'd1, 5'd8},   // R4 exact fit
        '{32'h00002001, 5'd10, 1'b1, 1'b1, 16'hFFFF, 2'd1, 5'd10},  // R6 all off
        '{32'h00003000, 5'd5,  1'b1, 1'b0, 16'h0013, 2'd1, 5'd5},   // R1 R7
        '{32'h00003004, 5'd16, 1'b1, 1'b1, 16'h1234, 2'd2, 5'd12}   // R6 R8
    };

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [VB*8-1:0] mk_data(input int k);
        logic [VB*8-1:0] d;
        for (int i = 0; i < VB; i++) d[i*8 +: 8] = 8'(k * 16 + i);
        return d;
    endfunction

    // Expected command from the requirements
    task automatic model(input vec_t v, input int k, input int part,
                         output logic [AW-1:0] e_addr, output logic [LW-1:0] e_len,
                         output logic [VB-1:0] e_strb, output logic [VB*8-1:0] e_data,
                         output bit e_split);
        int off, s_lo, s_hi, sh, pl;
        logic [VB*8-1:0] d;
        d = mk_data(k);
        off = int'(v.addr[3:0]);
        e_split = (off != 0);
        s_lo = (off == 0) ? int'(v.len) : (((VB - off) < int'(v.len)) ? (VB - off) : int'(v.len));
        s_hi = int'(v.len) - s_lo;
        sh = (part == 0) ? 0 : s_lo;
        pl = (part == 0) ? s_lo : s_hi;
        e_addr = v.addr + AW'(sh);
        e_len = LW'(pl);
        e_strb = '0;
        e_data = '0;
        for (int i = 0; i < VB; i++) begin
            if (i < pl) begin
                e_strb[i] = v.pen ? (v.pred[i + sh] ^ v.pinv) : 1'b1;
                e_data[i*8 +: 8] = d[(i + sh)*8 +: 8];
            end
        end
    endtask

    task automatic send(input vec_t v, input int k);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready before request", 128'(req_ready), 128'd1);
        req_addr = v.addr; req_len = v.len; req_data = mk_data(k);
        req_pred = v.pred; req_pred_en = v.pen; req_pred_inv = v.pinv;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic take_cmd(input vec_t v, input int k, input int part);
        logic [AW-1:0] ea; logic [LW-1:0] el; logic [VB-1:0] es;
        logic [VB*8-1:0] ed, dm; bit sp; int n;
        n = 0;
        while (!wr_valid && n < 10) begin @(negedge clk); n++; end
        model(v, k, part, ea, el, es, ed, sp);
        dm = '0;
        for (int i = 0; i < VB; i++) if (i < int'(el)) dm[i*8 +: 8] = 8'hFF;
        check(wr_valid == 1'b1, "R9 command present", 128'(wr_valid), 128'd1);
        check(req_ready == 1'b0, "R9 busy during command", 128'(req_ready), 128'd0);
        check(wr_addr == ea, (part == 0) ? "R2 first address" : "R3 second address", 128'(wr_addr), 128'(ea));
        check(wr_len == el, (part == 0) ? "R2 first length" : "R3 second length", 128'(wr_len), 128'(el));
        if (part == 0)
            check(wr_len == v.len_lo, "R2 table first length", 128'(wr_len), 128'(v.len_lo));
        check(wr_strb == es, v.pinv ? "R6 strobes" : "R5 R7 strobes", 128'(wr_strb), 128'(es));
        check((wr_data & dm) == (ed & dm), "R3 data bytes", wr_data & dm, ed & dm);
        check(wr_double == sp && wr_unaligned == sp, sp ? "R8 flags" : "R1 flags",
              128'({wr_double, wr_unaligned}), 128'({sp, sp}));
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        vec_t sv;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R11 ready in reset", 128'(req_ready), 128'd1);
        check(wr_valid == 1'b0, "R11 idle in reset", 128'(wr_valid), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && wr_valid == 1'b0, "R11 after reset", 128'({req_ready, wr_valid}), 128'b10);

        for (int t = 0; t < 8; t++) begin
            send(TBL[t], t);
            for (int p = 0; p < int'(TBL[t].ncmd); p++) take_cmd(TBL[t], t, p);
            check(wr_valid == 1'b0 && req_ready == 1'b1,
                  (TBL[t].ncmd == 2'd1) ? "R4 single command then idle" : "R9 idle after second",
                  128'({wr_valid, req_ready}), 128'b01);
        end

        // Stalled memory side: command must hold (R10), ready stays low (R9)
        sv = '{32'h00004005, 5'd16, 1'b1, 1'b0, 16'h5A5A, 2'd2, 5'd11};
        wr_ready = 1'b0;
        send(sv, 9);
        begin
            logic [AW-1:0] a0; logic [VB-1:0] s0;
            a0 = wr_addr; s0 = wr_strb;
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                check(wr_valid && wr_addr == a0 && wr_strb == s0, "R10 hold under stall",
                      128'({wr_addr, wr_strb}), 128'({a0, s0}));
                check(req_ready == 1'b0, "R9 ready low under stall", 128'(req_ready), 128'd0);
            end
        end
        wr_ready = 1'b1;
        take_cmd(sv, 9, 0);
        take_cmd(sv, 9, 1);
        check(wr_valid == 1'b0, "R9 done after stall", 128'(wr_valid), 128'd0);

        // Reset in the middle of a request
        wr_ready = 1'b0;
        send(sv, 10);
        rst_n = 1'b0;
        #1;
        check(wr_valid == 1'b0 && req_ready == 1'b1, "R11 reset mid request",
              128'({wr_valid, req_ready}), 128'b01);
        @(negedge clk);
        rst_n = 1'b1;
        wr_ready = 1'b1;
        @(negedge clk);
        check(wr_valid == 1'b0, "R11 no command after reset", 128'(wr_valid), 128'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule